// File: doc/BRIEF.md
# Media Port Auto-Select Controller

This block decides which of four media attachment ports is connected to the MAC's serial interface. The four ports are the attachment-unit port (AUI), the twisted-pair port, a direct attachment port (DAI) and a general-purpose serial port (GPSI). The block holds a small configuration register with a two-bit manual port field and an auto-select bit. When auto-select is clear, the manual field names the active port. When auto-select is set, the twisted-pair link state names the active port: twisted pair while the link passes, and AUI while it fails.

A port change is never applied in the middle of a frame. While the transmit-busy flag is high, the active port is frozen. A change that is waiting is applied on the first clock edge after the flag drops. The outputs are a one-hot port-enable vector and the level of an external transceiver-disable pin. Selecting the actual serial data paths from the enable vector is done elsewhere.

A configuration write lands on the next clock edge. The active port then follows on the edge after that, unless a transmission holds it. Both the hardware reset and the software reset clear the configuration bits.

Top module: `media_port_select`

## Requirements
- R1: While rst_n is low, on the next clock edge the active port becomes AUI: port_act = 4'b0001 and xcvr_dis = 1.
- R2: With auto-select clear, the manual field selects the port. Code 00 gives AUI (port_act bit 0), 01 gives twisted pair (bit 1), 10 gives DAI (bit 2) and 11 gives GPSI (bit 3). The port is active two clock edges after the cfg_wr cycle.
- R3: With auto-select set, the value of the manual field has no effect on port_act.
- R4: With auto-select set, twisted pair (bit 1) is chosen when link_pass is 1 or link_test_off is 1.
- R5: With auto-select set, AUI (bit 0) is chosen when link_pass and link_test_off are both 0.
- R6: While tx_busy is 1, port_act does not change. A pending change takes effect on the first clock edge where tx_busy is sampled 0.
- R7: xcvr_dis is 1 when AUI or twisted pair is active, and 0 when DAI or GPSI is active.
- R8: After reset, exactly one bit of port_act is 1 in every cycle.
- R9: A soft_rst pulse clears the manual field and the auto-select bit. soft_rst takes priority over cfg_wr in the same cycle. When it returns the port to AUI, that happens on the second clock edge, just as for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| soft_rst | input | 1 | Software reset of the configuration bits |
| cfg_wr | input | 1 | Load strobe for the configuration fields |
| cfg_sel | input | 2 | Manual port code |
| cfg_auto | input | 1 | Auto-select enable |
| link_pass | input | 1 | Twisted-pair link monitor reports pass |
| link_test_off | input | 1 | Link test disabled; forces pass |
| tx_busy | input | 1 | Transmission in progress |
| port_act | output | 4 | One-hot active port: bit 0 AUI, bit 1 TP, bit 2 DAI, bit 3 GPSI |
| xcvr_dis | output | 1 | External transceiver-disable pin level |

## Verification
The main function is exercised with a vector table.
- The manual rows cover all four codes, which shows the decode and the transceiver-disable level for each port.
- Auto rows that pair each link condition with differing manual codes show that the manual field is ignored.
- Auto rows that use the forced pass separate the two sources of link pass.

Directed sequences then cover the following:
- A frame that spans a manual change and a frame that spans a link drop show that the change is held back until tx_busy drops and then applied on the next edge.
- A software reset applied in auto mode with the link passing shows that both configuration bits are cleared.

// File: rtl/mps_pkg.sv
// Shared definitions for the media port select block.
// Assumes exactly four ports with fixed codes.
package mps_pkg;
    localparam int NUM_PORTS = 4;
    localparam int SEL_W     = $clog2(NUM_PORTS);

    typedef enum logic [SEL_W-1:0] {
        PORT_AUI  = 2'd0,
        PORT_TP   = 2'd1,
        PORT_DAI  = 2'd2,
        PORT_GPSI = 2'd3
    } port_e;
endpackage

// File: rtl/mps_cfg_reg.sv
// Configuration register: manual port code and auto-select enable.
// Assumes that soft_rst has priority over cfg_wr. Either reset clears both fields.
module mps_cfg_reg
    import mps_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          cfg_wr,
    input  logic [SW-1:0] cfg_sel,
    input  logic          cfg_auto,
    output logic [SW-1:0] sel_q,
    output logic          auto_q
);
    // Purpose: hold the configuration; clear it on hardware or software reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            sel_q  <= '0;
            auto_q <= 1'b0;
        end else if (cfg_wr) begin
            sel_q  <= cfg_sel;
            auto_q <= cfg_auto;
        end
    end
endmodule

// File: rtl/mps_target_sel.sv
// Works out which port should be active from the configuration and the link state.
// Assumes that link_test_off forces link pass. Purely combinational.
module mps_target_sel
    import mps_pkg::*;
(
    input  logic [SEL_W-1:0] sel_q,
    input  logic             auto_q,
    input  logic             link_pass,
    input  logic             link_test_off,
    output port_e            target
);
    logic link_ok;

    // Purpose: the effective link pass includes the forced pass.
    always_comb link_ok = link_pass | link_test_off;

    // Purpose: in auto mode the link chooses the port; otherwise the manual code does.
    always_comb begin
        if (auto_q) begin
            target = link_ok ? PORT_TP : PORT_AUI;
        end else begin
            target = port_e'(sel_q);
        end
    end
endmodule

// File: rtl/mps_port_switch.sv
// Holds the active port. Updates it only while no transmission is running.
// Decodes the port to a one-hot enable vector and the transceiver-disable level.
// Assumes that tx_busy is synchronous to clk.
module mps_port_switch
    import mps_pkg::*;
#(
    parameter int NP = NUM_PORTS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_busy,
    input  port_e         target,
    output logic [NP-1:0] port_act,
    output logic          xcvr_dis
);
    port_e cur_q;

    // Purpose: take the target port only between frames; reset to AUI.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= PORT_AUI;
        end else if (!tx_busy) begin
            cur_q <= target;
        end
    end

    // Purpose: one enable line per port.
    for (genvar i = 0; i < NP; i++) begin : g_dec
        assign port_act[i] = (cur_q == port_e'(i));
    end

    // Purpose: the on-chip transceiver ports keep the external one disabled.
    always_comb xcvr_dis = (cur_q == PORT_AUI) || (cur_q == PORT_TP);
endmodule

// File: rtl/media_port_select.sv
// Top level of the media port auto-select controller.
// Assumes that all inputs are synchronous to clk. Reset is synchronous and active low.
module media_port_select
    import mps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 cfg_wr,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic                 cfg_auto,
    input  logic                 link_pass,
    input  logic                 link_test_off,
    input  logic                 tx_busy,
    output logic [NUM_PORTS-1:0] port_act,
    output logic                 xcvr_dis
);
    logic [SEL_W-1:0] sel_q;
    logic             auto_q;
    port_e            target;

    mps_cfg_reg #(.SW(SEL_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .cfg_wr   (cfg_wr),
        .cfg_sel  (cfg_sel),
        .cfg_auto (cfg_auto),
        .sel_q    (sel_q),
        .auto_q   (auto_q)
    );

    mps_target_sel i_tgt (
        .sel_q         (sel_q),
        .auto_q        (auto_q),
        .link_pass     (link_pass),
        .link_test_off (link_test_off),
        .target        (target)
    );

    mps_port_switch #(.NP(NUM_PORTS)) i_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_busy  (tx_busy),
        .target   (target),
        .port_act (port_act),
        .xcvr_dis (xcvr_dis)
    );
endmodule

// File: rtl/mps_checker.sv
// Property checks for media_port_select, attached with bind.
module mps_checker
    import mps_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tx_busy,
    input logic                 link_pass,
    input logic                 link_test_off,
    input logic [SEL_W-1:0]     sel_q,
    input logic                 auto_q,
    input logic [NUM_PORTS-1:0] port_act,
    input logic                 xcvr_dis
);
    localparam logic [NUM_PORTS-1:0] ONE = NUM_PORTS'(1);

    // R8
    onehot_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(port_act) == 1);

    // R6
    hold_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> $stable(port_act));

    // R7
    xcvr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_dis == (port_act[0] | port_act[1]));

    // R2
    manual_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_q && !tx_busy) |=> port_act == (ONE << $past(sel_q)));

    // R4
    auto_tp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_q && !tx_busy && (link_pass || link_test_off)) |=> port_act == 4'b0010);

    // R5
    auto_aui_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_q && !tx_busy && !link_pass && !link_test_off) |=> port_act == 4'b0001);
endmodule

bind media_port_select mps_checker i_mps_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_busy       (tx_busy),
    .link_pass     (link_pass),
    .link_test_off (link_test_off),
    .sel_q         (sel_q),
    .auto_q        (auto_q),
    .port_act      (port_act),
    .xcvr_dis      (xcvr_dis)
);

// File: tb/test_media_port_select.sv
module test_media_port_select;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = 2'b00;
    logic       cfg_auto = 1'b0;
    logic       link_pass = 1'b0;
    logic       link_test_off = 1'b0;
    logic       tx_busy = 1'b0;
    logic [3:0] port_act;
    logic       xcvr_dis;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    media_port_select i_media_port_select (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .cfg_wr        (cfg_wr),
        .cfg_sel       (cfg_sel),
        .cfg_auto      (cfg_auto),
        .link_pass     (link_pass),
        .link_test_off (link_test_off),
        .tx_busy       (tx_busy),
        .port_act      (port_act),
        .xcvr_dis      (xcvr_dis)
    );

    // Vector fields: [8:7] sel, [6] auto, [5] link_pass, [4] link_test_off, [3:0] expected port_act
    localparam int NV = 12;
    localparam logic [8:0] VEC [NV] = '{
        {2'b00, 1'b0, 1'b0, 1'b0, 4'b0001},  // R2 AUI
        {2'b01, 1'b0, 1'b0, 1'b0, 4'b0010},  // R2 TP
        {2'b10, 1'b0, 1'b1, 1'b0, 4'b0100},  // R2 DAI
        {2'b11, 1'b0, 1'b1, 1'b1, 4'b1000},  // R2 GPSI
        {2'b11, 1'b1, 1'b1, 1'b0, 4'b0010},  // R3 R4
        {2'b10, 1'b1, 1'b1, 1'b0, 4'b0010},  // R3 R4
        {2'b00, 1'b1, 1'b0, 1'b1, 4'b0010},  // R4 forced pass
        {2'b11, 1'b1, 1'b0, 1'b0, 4'b0001},  // R3 R5
        {2'b01, 1'b1, 1'b0, 1'b0, 4'b0001},  // R3 R5
        {2'b10, 1'b1, 1'b0, 1'b0, 4'b0001},  // R3 R5
        {2'b10, 1'b0, 1'b0, 1'b0, 4'b0100},  // R2 back to manual
        {2'b01, 1'b0, 1'b1, 1'b1, 4'b0010}   // R2
    };

    task automatic check_act(input string req, input logic [3:0] exp);
        n_run++;
        if (port_act !== exp) begin
            n_fail++;
            $display("FAIL %s port_act actual=%b expected=%b", req, port_act, exp);
        end
    endtask

    task automatic check_dis(input string req, input logic exp);
        n_run++;
        if (xcvr_dis !== exp) begin
            n_fail++;
            $display("FAIL %s xcvr_dis actual=%b expected=%b", req, xcvr_dis, exp);
        end
    endtask

    task automatic check_one(input string req);
        n_run++;
        if ($countones(port_act) != 1) begin
            n_fail++;
            $display("FAIL %s port_act actual=%b expected=one bit set", req, port_act);
        end
    endtask

    // Write the configuration at a negedge. Returns at the negedge after the port register has loaded.
    task automatic write_cfg(input logic [1:0] s, input logic a);
        cfg_sel  = s;
        cfg_auto = a;
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        string tag;
        // R1: reset state
        repeat (3) @(negedge clk);
        check_act("R1", 4'b0001);
        check_dis("R1", 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check_act("R1", 4'b0001);

        // Vector table: R2, R3, R4, R5, R7, R8
        for (int i = 0; i < NV; i++) begin
            link_pass     = VEC[i][5];
            link_test_off = VEC[i][4];
            write_cfg(VEC[i][8:7], VEC[i][6]);
            if (VEC[i][6]) tag = (VEC[i][5] || VEC[i][4]) ? "R4/R3" : "R5/R3";
            else tag = "R2";
            check_act(tag, VEC[i][3:0]);
            check_dis("R7", VEC[i][1] | VEC[i][0]);
            check_one("R8");
        end

        // R6: a manual change during a frame is deferred
        write_cfg(2'b00, 1'b0);
        check_act("R6", 4'b0001);
        tx_busy = 1'b1;
        write_cfg(2'b10, 1'b0);
        repeat (4) @(negedge clk);
        check_act("R6", 4'b0001);
        check_dis("R6", 1'b1);
        tx_busy = 1'b0;
        @(negedge clk);
        check_act("R6", 4'b0100);

        // R6: a link drop during a frame in auto mode is deferred
        link_pass = 1'b1;
        link_test_off = 1'b0;
        write_cfg(2'b11, 1'b1);
        check_act("R4", 4'b0010);
        tx_busy = 1'b1;
        @(negedge clk);
        link_pass = 1'b0;
        repeat (3) @(negedge clk);
        check_act("R6", 4'b0010);
        tx_busy = 1'b0;
        @(negedge clk);
        check_act("R6", 4'b0001);

        // R9: soft reset clears auto-select; with the link passing this shows the clear
        link_pass = 1'b1;
        write_cfg(2'b11, 1'b1);
        check_act("R9", 4'b0010);
        soft_rst = 1'b1;
        cfg_wr   = 1'b1;
        cfg_sel  = 2'b11;
        cfg_auto = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        cfg_wr   = 1'b0;
        @(negedge clk);
        check_act("R9", 4'b0001);
        check_dis("R9", 1'b1);

        // R9: soft reset clears the manual field
        write_cfg(2'b11, 1'b0);
        check_act("R2", 4'b1000);
        check_dis("R7", 1'b0);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        @(negedge clk);
        check_act("R9", 4'b0001);

        // R1: hardware reset during a frame still forces AUI
        write_cfg(2'b10, 1'b0);
        tx_busy = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check_act("R1", 4'b0001);
        rst_n = 1'b1;
        tx_busy = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_act("R1", 4'b0001);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule